// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

The block is a register-programmed watchdog. A down-counter is loaded from a programmable tick count and decrements on every clock cycle in which the tick-enable input is high. When the count runs out the first time, the block sets a first-timeout status flag and raises an interrupt request. It then reloads itself and counts down a second time. If software does not service the timer before the second expiry, the block asserts a one-cycle system reset request. A no-reboot control bit can block that request. In that case a boot status flag is set instead.

Software reaches the block through a simple synchronous register port: address, write enable, write data and combinational read data. It programs the timeout and releases the halt bit to start the timer. Any write to the service address restarts the countdown and cancels a pending second stage. Status flags are cleared by writing ones to them. A routing bit can forward the second-stage event to the interrupt line. This gives a fallback path when reboots stay blocked.

Top module: `wdt_dual_stage`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x0005: halt bit 0 set, route bit 1 clear, no-reboot bit 2 set. STATUS bits [2:0] read 0, `irq_o` is 0 and `rst_req_o` is 0.
- R2: While CTRL bit 0 (halt) is 1, the count value (readable at address 4) holds. After the bit is cleared, counting resumes from the held value.
- R3: A write of any data value to address 2 (service) loads the count from the timeout field and returns the timer to the first stage, discarding a pending second stage.
- R4: Address 1 is a 16-bit read/write timeout register. Only bits [9:0] set the tick count. Bits [15:10] read back as written and do not affect counting.
- R5: STATUS bit 3 reads 1 exactly when the timeout field is below MIN_TICKS (4) or above MAX_TICKS (1022).
- R6: The count changes only on cycles with `tick_en_i` high. The first expiry comes on the Nth tick after a service write with timeout N. It sets STATUS bit 0 and reloads the count from the timeout field.
- R7: The Nth tick after a first expiry, with no service write in between, is the second expiry. It sets STATUS bit 1. If no-reboot is 0, it also drives `rst_req_o` high for exactly one cycle.
- R8: With CTRL bit 2 (no-reboot) set, a second expiry does not assert `rst_req_o` and sets STATUS bit 2 (boot). The bit is writable, and its cleared value reads back.
- R9: Writing 1 to STATUS bits 0, 1 or 2 clears only those bits. Writing 0 leaves them unchanged.
- R10: `irq_o` is high when STATUS bit 0 is set, or when STATUS bit 1 is set and CTRL bit 1 (route) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for `addr_i`, combinational |
| tick_en_i | input | 1 | Count enable for one tick |
| irq_o | output | 1 | Interrupt request, level |
| rst_req_o | output | 1 | System reset request, one-cycle pulse |

## Verification
The assertions check the following on every cycle:
- the count stays frozen while halted or while no tick arrives;
- a service write loads the programmed field;
- the reset request lasts exactly one cycle and never follows a cycle with no-reboot set;
- the interrupt is high whenever the first-timeout flag rises.

Some behaviours only the bench scenarios can show:
- the expiry distances of N and 2N ticks across a sweep of timeouts and tick spacings;
- that a mid-run service write cancels the second stage;
- the boundaries of the range flag;
- the write-one-to-clear behaviour of the individual status bits.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_TMO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_KICK = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

    typedef struct packed {
        logic noreboot;   // bit 2
        logic route;      // bit 1
        logic halt;       // bit 0
    } ctrl_t;

    typedef struct packed {
        logic boot;       // bit 2
        logic second;     // bit 1
        logic first;      // bit 0
    } evt_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt2_pkg::*;
#(
    parameter int TICK_W    = 10,
    parameter int RST_TICKS = 4,
    parameter int MIN_TICKS = 4,
    parameter int MAX_TICKS = 1022,
    parameter bit NR_LOCKED = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  evt_t              evt_i,
    input  logic [TICK_W-1:0] cnt_i,
    output ctrl_t             ctrl_o,
    output logic [TICK_W-1:0] tmo_ticks_o,
    output logic              kick_o,
    output evt_t              sts_o
);

    localparam logic [TICK_W-1:0] MIN_L = TICK_W'(MIN_TICKS);
    localparam logic [TICK_W-1:0] MAX_L = TICK_W'(MAX_TICKS);
    localparam logic [DATA_W-1:0] TMO_RST = DATA_W'(RST_TICKS);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] tmo;
        evt_t              sts;
    } regs_t;

    regs_t d, q;
    logic  nr_wr;
    logic  range_err;

    // The no-reboot bit is either freely writable or stuck at one
    generate
        if (NR_LOCKED) begin : g_nr_locked
            assign nr_wr = 1'b1;
        end else begin : g_nr_free
            assign nr_wr = wr_data_i[2];
        end
    endgenerate

    assign range_err = (q.tmo[TICK_W-1:0] < MIN_L) || (q.tmo[TICK_W-1:0] > MAX_L);

    always_comb begin
        d = q;
        if (wr_en_i && addr_i == A_CTRL) begin
            d.ctrl.halt     = wr_data_i[0];
            d.ctrl.route    = wr_data_i[1];
            d.ctrl.noreboot = nr_wr;
        end
        if (wr_en_i && addr_i == A_TMO) begin
            d.tmo = wr_data_i;
        end
        // Write-one-to-clear; a new event in the same cycle wins
        if (wr_en_i && addr_i == A_STAT) begin
            d.sts = q.sts & ~evt_t'(wr_data_i[2:0]);
        end
        d.sts = d.sts | evt_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.ctrl <= '{noreboot: 1'b1, route: 1'b0, halt: 1'b1};
            q.tmo  <= TMO_RST;
            q.sts  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rd_data_o = DATA_W'(q.ctrl);
            A_TMO:   rd_data_o = q.tmo;
            A_STAT:  rd_data_o = DATA_W'({range_err, q.sts});
            A_CNT:   rd_data_o = DATA_W'(cnt_i);
            default: rd_data_o = '0;
        endcase
    end

    assign kick_o      = wr_en_i && (addr_i == A_KICK);
    assign ctrl_o      = q.ctrl;
    assign tmo_ticks_o = q.tmo[TICK_W-1:0];
    assign sts_o       = q.sts;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt2_pkg::*;
#(
    parameter int TICK_W    = 10,
    parameter int RST_TICKS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_en_i,
    input  logic              halt_i,
    input  logic              noreboot_i,
    input  logic              kick_i,
    input  logic [TICK_W-1:0] tmo_ticks_i,
    output logic [TICK_W-1:0] cnt_o,
    output evt_t              evt_o,
    output logic              rst_req_o
);

    localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

    typedef struct packed {
        logic [TICK_W-1:0] cnt;
        logic              stage;    // 0: first countdown, 1: second countdown
        logic              rst_req;
    } core_t;

    core_t d, q;
    evt_t  evt;

    always_comb begin
        d         = q;
        d.rst_req = 1'b0;
        evt       = '0;
        if (kick_i) begin
            d.cnt   = tmo_ticks_i;
            d.stage = 1'b0;
        end else if (!halt_i && tick_en_i) begin
            if (q.cnt <= ONE) begin
                // Count reaches zero on this tick
                d.cnt = tmo_ticks_i;
                if (!q.stage) begin
                    evt.first = 1'b1;
                    d.stage   = 1'b1;
                end else begin
                    evt.second = 1'b1;
                    d.stage    = 1'b0;
                    if (noreboot_i) begin
                        evt.boot = 1'b1;
                    end else begin
                        d.rst_req = 1'b1;
                    end
                end
            end else begin
                d.cnt = q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.cnt     <= TICK_W'(RST_TICKS);
            q.stage   <= 1'b0;
            q.rst_req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o     = q.cnt;
    assign evt_o     = evt;
    assign rst_req_o = q.rst_req;

endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage
    import wdt2_pkg::*;
#(
    parameter int TICK_W    = 10,
    parameter int RST_TICKS = 4,
    parameter int MIN_TICKS = 4,
    parameter int MAX_TICKS = 1022,
    parameter bit NR_LOCKED = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [2:0]  addr_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] rd_data_o,
    input  logic        tick_en_i,
    output logic        irq_o,
    output logic        rst_req_o
);

    logic              kick;
    ctrl_t             ctrl;
    logic [TICK_W-1:0] cnt;
    logic [TICK_W-1:0] tmo_ticks;
    evt_t              evt;
    evt_t              sts;

    wdt_regs #(
        .TICK_W   (TICK_W),
        .RST_TICKS(RST_TICKS),
        .MIN_TICKS(MIN_TICKS),
        .MAX_TICKS(MAX_TICKS),
        .NR_LOCKED(NR_LOCKED)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .evt_i      (evt),
        .cnt_i      (cnt),
        .ctrl_o     (ctrl),
        .tmo_ticks_o(tmo_ticks),
        .kick_o     (kick),
        .sts_o      (sts)
    );

    wdt_core #(
        .TICK_W   (TICK_W),
        .RST_TICKS(RST_TICKS)
    ) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_en_i  (tick_en_i),
        .halt_i     (ctrl.halt),
        .noreboot_i (ctrl.noreboot),
        .kick_i     (kick),
        .tmo_ticks_i(tmo_ticks),
        .cnt_o      (cnt),
        .evt_o      (evt),
        .rst_req_o  (rst_req_o)
    );

    assign irq_o = sts.first | (ctrl.route & sts.second);

endmodule

// File: rtl/wdt_dual_stage_chk.sv
module wdt_dual_stage_chk #(
    parameter int TICK_W = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_en_i,
    input logic              kick_i,
    input logic              halt_i,
    input logic              noreboot_i,
    input logic [TICK_W-1:0] cnt_i,
    input logic [TICK_W-1:0] tmo_ticks_i,
    input logic              sts_first_i,
    input logic              irq_i,
    input logic              rst_req_i
);

    // R2: halted counter holds unless serviced
    a_r2_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && !kick_i) |=> $stable(cnt_i));

    // R3: service write loads the programmed field
    a_r3_kick_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |=> (cnt_i == $past(tmo_ticks_i)));

    // R6: no tick, no count change
    a_r6_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_en_i && !kick_i) |=> $stable(cnt_i));

    // R7: reset request is a single-cycle pulse
    a_r7_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |=> !rst_req_i);

    // R8: no reset request while reboot was blocked
    a_r8_noreboot_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |-> $past(!noreboot_i));

    // R10: first-timeout flag raises the interrupt
    a_r10_irq_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_first_i) |-> irq_i);

endmodule

bind wdt_dual_stage wdt_dual_stage_chk #(.TICK_W(TICK_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .kick_i     (kick),
    .halt_i     (ctrl.halt),
    .noreboot_i (ctrl.noreboot),
    .cnt_i      (cnt),
    .tmo_ticks_i(tmo_ticks),
    .sts_first_i(sts.first),
    .irq_i      (irq_o),
    .rst_req_i  (rst_req_o)
);

// File: tb/sim_wdt_dual_stage.sv
`timescale 1ns/1ps
module sim_wdt_dual_stage;

    localparam logic [2:0] A_CTRL = 3'd0, A_TMO = 3'd1, A_KICK = 3'd2,
                           A_STAT = 3'd3, A_CNT = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        tick = 1'b0;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    int rst_pulses = 0;
    int rst_run = 0;
    int rst_longest = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_dual_stage u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .addr_i   (addr),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .rd_data_o(rd_data),
        .tick_en_i(tick),
        .irq_o    (irq),
        .rst_req_o(rst_req)
    );

    always @(negedge clk) begin
        if (rst_req) begin
            rst_run = rst_run + 1;
            if (rst_run == 1) rst_pulses = rst_pulses + 1;
            if (rst_run > rst_longest) rst_longest = rst_run;
        end else begin
            rst_run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        addr = a; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    // Run with tick high every 'period' cycles until STATUS bit 'b' sets
    task automatic run_until(input int b, input int period, output int ticks);
        logic [15:0] s;
        ticks = 0;
        for (int k = 0; k < 20000; k++) begin
            tick = (k % period == 0);
            @(posedge clk);
            if (tick) ticks++;
            @(negedge clk);
            tick = 1'b0;
            rd(A_STAT, s);
            if (s[b]) return;
        end
        ticks = -1;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int t1, t2, pulses0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1", v, 16'h0005, "ctrl after reset");
        rd(A_STAT, v); chk("R1", v[2:0], 0, "status after reset");
        chk("R1", irq, 0, "irq after reset");
        chk("R1", rst_req, 0, "rst_req after reset");

        // R2 halt freezes count
        wr(A_TMO, 16'd6);
        wr(A_KICK, 16'h1234);
        tick_n(15);
        rd(A_CNT, v); chk("R2", v, 6, "count while halted");
        wr(A_CTRL, 16'h0000);
        tick_n(2);
        rd(A_CNT, v); chk("R2", v, 4, "count after resume");
        rd(A_STAT, v); chk("R2", v[2:0], 0, "no expiry while halted");

        // R4 upper bits preserved and ignored
        wr(A_CTRL, 16'h0001);
        wr(A_TMO, 16'hFC07);
        rd(A_TMO, v); chk("R4", v, 16'hFC07, "timeout readback");
        wr(A_KICK, 16'h0000);
        rd(A_CNT, v); chk("R4", v, 7, "count loaded from low field");

        // R5 range flag boundaries
        wr(A_TMO, 16'd3);    rd(A_STAT, v); chk("R5", v[3], 1, "below min");
        wr(A_TMO, 16'd4);    rd(A_STAT, v); chk("R5", v[3], 0, "at min");
        wr(A_TMO, 16'd1022); rd(A_STAT, v); chk("R5", v[3], 0, "at max");
        wr(A_TMO, 16'd1023); rd(A_STAT, v); chk("R5", v[3], 1, "above max");

        // R8 no-reboot readback
        wr(A_CTRL, 16'h0001);
        rd(A_CTRL, v); chk("R8", v[2], 0, "no-reboot cleared readback");

        // R6 R7 sweep over timeout and tick spacing
        for (int n = 1; n <= 10; n++) begin
            for (int p = 1; p <= 3; p += 2) begin
                wr(A_CTRL, 16'h0001);
                wr(A_STAT, 16'h0007);
                wr(A_TMO, 16'(n));
                wr(A_CTRL, 16'h0000);
                wr(A_KICK, 16'(n * 77));
                pulses0 = rst_pulses;
                run_until(0, p, t1);
                chk("R6", t1, n, $sformatf("ticks to first expiry n=%0d p=%0d", n, p));
                chk("R10", irq, 1, "irq on first expiry");
                chk("R7", rst_pulses, pulses0, "no reset at first expiry");
                run_until(1, p, t2);
                chk("R7", t2, n, $sformatf("ticks to second expiry n=%0d p=%0d", n, p));
                @(negedge clk); @(negedge clk);
                chk("R7", rst_pulses - pulses0, 1, "one reset request");
            end
        end
        wr(A_CTRL, 16'h0001);
        chk("R7", rst_longest, 1, "reset pulse width");

        // R3 service cancels pending second stage
        wr(A_STAT, 16'h0007);
        wr(A_TMO, 16'd5);
        wr(A_CTRL, 16'h0000);
        wr(A_KICK, 16'h0000);
        pulses0 = rst_pulses;
        run_until(0, 1, t1);
        chk("R3", t1, 5, "first expiry before service");
        wr(A_STAT, 16'h0001);
        wr(A_KICK, 16'hFFFF);
        tick_n(4);
        rd(A_STAT, v); chk("R3", v[2:0], 0, "nothing before full period");
        tick_n(1);
        rd(A_STAT, v); chk("R3", v[2:0], 1, "first stage again after service");
        chk("R3", rst_pulses, pulses0, "no reset after service");

        // R8 blocked reboot sets boot status
        wr(A_CTRL, 16'h0005);
        wr(A_STAT, 16'h0007);
        wr(A_TMO, 16'd4);
        wr(A_CTRL, 16'h0006);
        wr(A_KICK, 16'h0042);
        pulses0 = rst_pulses;
        run_until(0, 1, t1);
        run_until(1, 1, t2);
        @(negedge clk);
        chk("R8", rst_pulses, pulses0, "reset blocked");
        rd(A_STAT, v); chk("R8", v[2:0], 7, "boot status set");
        wr(A_CTRL, 16'h0007);

        // R9 / R10 clear and routing
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v); chk("R9", v[2:0], 6, "clear first only");
        chk("R10", irq, 1, "second routed to irq");
        wr(A_CTRL, 16'h0005);
        chk("R10", irq, 0, "second not routed");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); chk("R9", v[2:0], 6, "write zero keeps status");
        wr(A_STAT, 16'h0002);
        rd(A_STAT, v); chk("R9", v[2:0], 4, "clear second only");
        wr(A_STAT, 16'h0004);
        rd(A_STAT, v); chk("R9", v[2:0], 0, "clear boot");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule